// File: doc/BRIEF.md
# Local Exclusive Access Monitor

This block keeps the exclusive-access reservation for one core in a single-core microcontroller. It watches the decoded instruction stream for load-exclusive, store-exclusive, clear-exclusive and ordinary store operations. It also watches the exception entry and exception exit strobes. For each store-exclusive it drives a memory write enable in the same cycle. One cycle later it reports a pass/fail status.

The reservation is a single open/closed flag and carries no address. The whole memory space is therefore one reservation granule. A load-exclusive to any address opens the monitor, and a store-exclusive to any address succeeds while the monitor is open. Exception entry and exception exit close the monitor, so a sequence interrupted by an exception fails. Software then retries. When a zero-wait bus answers a passing store-exclusive with a plain OKAY instead of an exclusive OKAY, the reported status becomes failure.

Top module: `excl_monitor`

## Requirements
- R1: After reset the monitor is closed: a store-exclusive issued before any load-exclusive fails and does not assert `mem_we_o`.
- R2: A load-exclusive (`op_i`=1 with `op_valid_i`=1) opens the monitor. A following store-exclusive (`op_i`=2) passes and asserts `mem_we_o` in its own cycle.
- R3: The block takes no address. After two load-exclusives in a row, the next store-exclusive passes.
- R4: Every store-exclusive closes the monitor, whether it passes or fails. A second store-exclusive with no new load-exclusive fails.
- R5: A clear-exclusive (`op_i`=3) closes the monitor.
- R6: Exception entry (`exc_entry_i`) and exception exit (`exc_exit_i`) each close the monitor, with the same effect as a clear-exclusive.
- R7: If an exception strobe arrives in the same cycle as a store-exclusive, the store-exclusive fails and `mem_we_o` stays low.
- R8: If an exception strobe arrives in the same cycle as a load-exclusive, the monitor stays closed.
- R9: The following cycles leave the monitor state unchanged: an ordinary store (`op_i`=4), an idle code (`op_i`=0, 5, 6, 7), and any code with `op_valid_i`=0.
- R10: `stx_done_o` is 1 in exactly the cycle after each store-exclusive. `stx_fail_o` then reads 0 for success and 1 for failure.
- R11: If `bus_exokay_i` is 0 in the cycle of a passing store-exclusive, `mem_we_o` still asserts but the reported status is failure.
- R12: `mem_we_o` is high only in the cycle of a passing store-exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Decoded operation valid |
| op_i | input | 3 | Operation code: 0 idle, 1 load-excl, 2 store-excl, 3 clear-excl, 4 ordinary store |
| exc_entry_i | input | 1 | Exception entry strobe |
| exc_exit_i | input | 1 | Exception exit strobe |
| bus_exokay_i | input | 1 | Bus answered exclusive OKAY in the current store cycle |
| mem_we_o | output | 1 | Write enable for a passing store-exclusive |
| stx_done_o | output | 1 | Store-exclusive status valid |
| stx_fail_o | output | 1 | Store-exclusive status, 1 means failure |

## Verification
The only hidden state is the open/closed flag, and the ports show it only when a store-exclusive arrives. A flag left open wrongly shows up as a spurious `mem_we_o` on the next store-exclusive. A flag left closed wrongly shows up as a missing write and a `stx_fail_o` of 1 one cycle later. The bench therefore closes each scenario with a store-exclusive, and it places a store-exclusive after every clear, exception and ignored-operation cycle, so that any corrupted state appears within one or two cycles.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_IDLE = 3'd0,
    OP_LDX  = 3'd1,
    OP_STX  = 3'd2,
    OP_CLRX = 3'd3,
    OP_ST   = 3'd4
  } op_e;
endpackage

// File: rtl/excl_op_decode.sv
module excl_op_decode
  import excl_mon_pkg::*;
(
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            entry_i,
  input  logic            exit_i,
  output logic            ldx_o,
  output logic            stx_o,
  output logic            clrx_o,
  output logic            exc_o
);
  always_comb begin
    ldx_o  = 1'b0;
    stx_o  = 1'b0;
    clrx_o = 1'b0;
    if (valid_i) begin
      unique case (op_i)
        OP_LDX:  ldx_o  = 1'b1;
        OP_STX:  stx_o  = 1'b1;
        OP_CLRX: clrx_o = 1'b1;
        default: ; // ordinary store and idle codes do not touch the reservation
      endcase
    end
  end

  assign exc_o = entry_i | exit_i;
endmodule

// File: rtl/excl_resv.sv
module excl_resv (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic close_i,
  output logic open_o
);
  logic open_q;

  // close wins over set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      open_q <= 1'b0;
    else if (close_i) open_q <= 1'b0;
    else if (set_i)   open_q <= 1'b1;
  end

  assign open_o = open_q;
endmodule

// File: rtl/excl_stx_status.sv
module excl_stx_status #(
  parameter bit CHECK_RESP = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stx_i,
  input  logic pass_i,
  input  logic exokay_i,
  output logic done_o,
  output logic fail_o
);
  logic ok;
  logic done_q, fail_q;

  generate
    if (CHECK_RESP) begin : g_resp
      assign ok = pass_i & exokay_i;
    end else begin : g_noresp
      assign ok = pass_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      done_q <= stx_i;
      if (stx_i) fail_q <= ~ok;
    end
  end

  assign done_o = done_q;
  assign fail_o = fail_q;
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_mon_pkg::*;
#(
  parameter bit CHECK_RESP = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            op_valid_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            exc_entry_i,
  input  logic            exc_exit_i,
  input  logic            bus_exokay_i,
  output logic            mem_we_o,
  output logic            stx_done_o,
  output logic            stx_fail_o
);
  logic ldx, stx, clrx, exc;
  logic open_q, pass;

  excl_op_decode u_dec (
    .valid_i (op_valid_i),
    .op_i    (op_i),
    .entry_i (exc_entry_i),
    .exit_i  (exc_exit_i),
    .ldx_o   (ldx),
    .stx_o   (stx),
    .clrx_o  (clrx),
    .exc_o   (exc)
  );

  excl_resv u_resv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (ldx),
    .close_i (stx | clrx | exc),
    .open_o  (open_q)
  );

  // an exception in the same cycle kills the store
  assign pass     = stx & open_q & ~exc;
  assign mem_we_o = pass;

  excl_stx_status #(.CHECK_RESP(CHECK_RESP)) u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stx_i    (stx),
    .pass_i   (pass),
    .exokay_i (bus_exokay_i),
    .done_o   (stx_done_o),
    .fail_o   (stx_fail_o)
  );
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ldx_i,
  input logic stx_i,
  input logic clrx_i,
  input logic exc_i,
  input logic open_i,
  input logic we_i,
  input logic done_i,
  input logic fail_i
);
  assert_we_needs_open_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (stx_i && open_i));
  assert_exc_blocks_we_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stx_i && exc_i) |-> !we_i);
  assert_stx_closes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stx_i |=> !open_i);
  assert_clrx_closes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clrx_i |=> !open_i);
  assert_exc_closes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i |=> !open_i);
  assert_ldx_opens_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ldx_i && !exc_i) |=> open_i);
  assert_done_timing_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stx_i |=> done_i);
  assert_done_only_after_stx_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stx_i |=> !done_i);
  assert_blocked_fails_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stx_i && !we_i) |=> fail_i);
endmodule

bind excl_monitor excl_monitor_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ldx_i  (ldx),
  .stx_i  (stx),
  .clrx_i (clrx),
  .exc_i  (exc),
  .open_i (open_q),
  .we_i   (mem_we_o),
  .done_i (stx_done_o),
  .fail_i (stx_fail_o)
);

// File: tb/excl_monitor_tb_top.sv
module excl_monitor_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [2:0] op = 3'd0;
  logic       entry = 1'b0, exitp = 1'b0, exok = 1'b1;
  logic       we, done, fail;

  int vectors = 0;
  int errors  = 0;
  bit finished = 0;

  // reference model state
  bit m_open = 0;
  bit m_done = 0;
  bit m_fail = 0;

  always #5 clk = ~clk;

  excl_monitor dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .op_valid_i   (op_valid),
    .op_i         (op),
    .exc_entry_i  (entry),
    .exc_exit_i   (exitp),
    .bus_exokay_i (exok),
    .mem_we_o     (we),
    .stx_done_o   (done),
    .stx_fail_o   (fail)
  );

  task automatic cmp(input string req, input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // one cycle: drive after negedge, compare, then advance model at the edge
  task automatic step(input string req, input bit v, input logic [2:0] o,
                      input bit en, input bit ex, input bit ok);
    bit is_ldx, is_stx, is_clr, is_exc, exp_we;
    @(negedge clk);
    op_valid = v; op = o; entry = en; exitp = ex; exok = ok;
    #1;
    is_ldx = v && (o == 3'd1);
    is_stx = v && (o == 3'd2);
    is_clr = v && (o == 3'd3);
    is_exc = en || ex;
    exp_we = is_stx && m_open && !is_exc;
    cmp(req, "mem_we", we, exp_we);
    cmp(req, "stx_done", done, m_done);
    if (m_done) cmp(req, "stx_fail", fail, m_fail);
    m_done = is_stx;
    if (is_stx) m_fail = !(exp_we && ok);
    if (is_stx || is_clr || is_exc) m_open = 0;
    else if (is_ldx) m_open = 1;
  endtask

  task automatic ldx(input string r);  step(r, 1, 3'd1, 0, 0, 1); endtask
  task automatic stx(input string r);  step(r, 1, 3'd2, 0, 0, 1); endtask
  task automatic idle(input string r); step(r, 0, 3'd0, 0, 0, 1); endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #12;
    cmp("R1", "reset we", we, 1'b0);
    cmp("R1", "reset done", done, 1'b0);
    rst_n = 1'b1;
    // R1: store-exclusive straight after reset fails
    stx("R1"); idle("R1");
    // R2 / R10: basic pass
    ldx("R2"); stx("R2"); idle("R10");
    // R3: two loads, store passes
    ldx("R3"); ldx("R3"); stx("R3"); idle("R3");
    // R4: second store fails
    ldx("R4"); stx("R4"); stx("R4"); idle("R4");
    // R5: clear-exclusive
    ldx("R5"); step("R5", 1, 3'd3, 0, 0, 1); stx("R5"); idle("R5");
    // R6: entry, then exit
    ldx("R6"); step("R6", 0, 3'd0, 1, 0, 1); stx("R6");
    ldx("R6"); step("R6", 0, 3'd0, 0, 1, 1); stx("R6"); idle("R6");
    // R7: exception coincident with store
    ldx("R7"); step("R7", 1, 3'd2, 1, 0, 1); idle("R7");
    ldx("R7"); step("R7", 1, 3'd2, 0, 1, 1); idle("R7");
    // R8: exception coincident with load
    step("R8", 1, 3'd1, 1, 0, 1); stx("R8"); idle("R8");
    // R9: ordinary store, idle codes, invalid ops keep open state
    ldx("R9"); step("R9", 1, 3'd4, 0, 0, 1); step("R9", 1, 3'd5, 0, 0, 1);
    step("R9", 1, 3'd7, 0, 0, 1); step("R9", 0, 3'd3, 0, 0, 1);
    step("R9", 0, 3'd2, 0, 0, 1); stx("R9"); idle("R9");
    // R9: ignored ops do not open a closed monitor
    step("R9", 0, 3'd1, 0, 0, 1); step("R9", 1, 3'd6, 0, 0, 1); stx("R9"); idle("R9");
    // R11: plain OKAY forces failure
    ldx("R11"); step("R11", 1, 3'd2, 0, 0, 0); idle("R11");
    ldx("R11"); step("R11", 1, 3'd2, 0, 0, 0); stx("R11"); idle("R11");
    // R12: back-to-back mixed traffic
    for (int i = 0; i < 40; i++) begin
      step("R12", (i % 7) != 3, 3'((i * 5 + 1) % 8), (i % 11) == 4, (i % 13) == 6, (i % 5) != 2);
    end
    idle("R12"); idle("R12");
    finish_run();
  end
endmodule